// File: doc/BRIEF.md
# Multi-Pulse Gain-Control Start Generator

This block sits on the line that starts an automatic gain control (AGC) engine. A receive capture begins with one trigger event. Some captures hold several preambles, each sent at a different time, and the AGC engine has to lock again on each one. The engine only starts on a rising edge of its start line. After it starts, it ignores further starts until its own timeout clears it. This block therefore turns one rising edge on the trigger into a train of one-cycle start pulses. The pulses are spaced by the configured AGC timeout plus a guard delay, so each one lands just after the engine is ready again.

The train is limited to a capture window counted from its first pulse. When the window ends, the block returns to idle and waits for the next trigger. The timeout, guard and window values are captured when the trigger is accepted, so writes made during a capture only affect the next one. A mode input selects between the pulse train and a direct pass-through of the existing single-trigger path.

Top module: `agc_retrig_gen`

## Requirements
- R1: While reset is held, and right after it, with the train mode selected, the start output is low and no train is running.
- R2: In train mode with no train running, a rising edge on the trigger is detected at the first clock edge that samples it high. The first start pulse is high during the clock cycle right after that edge.
- R3: Every generated start pulse is high for exactly one clock cycle, so each start is a fresh rising edge.
- R4: The spacing between generated pulses, in clock cycles, is the captured timeout plus the captured guard delay.
- R5: If the timeout plus guard is below 2, the spacing is 2 cycles, so the output always returns low between pulses.
- R6: A train issues pulses only at offsets (0, P, 2P, ...) smaller than the captured window W. A window of 0 behaves as 1, giving exactly one pulse. At offset W the train ends and the block is idle again.
- R7: Timeout, guard and window are sampled on the cycle the trigger is accepted. Changing them during a running train does not change that train.
- R8: A trigger rising edge that arrives while a train is running is ignored. A trigger held high past the end of a train does not start a new one.
- R9: With the mode input low, the start output follows the pass-through input in the same cycle. Trigger edges seen in that mode start no train.
- R10: With timeout 32768, guard 0 and window 32768, one trigger produces exactly one start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Incoming capture trigger; its rising edge starts a train |
| passthru_in | input | 1 | Existing single-trigger start path |
| mode_multi | input | 1 | 1 selects the pulse train, 0 selects pass-through |
| cfg_timeout | input | TW (16) | AGC timeout in cycles |
| cfg_guard | input | GW (8) | Extra guard delay added after the timeout |
| cfg_window | input | WW (16) | Capture window length in cycles |
| agc_start | output | 1 | Start line to the gain-control engine |

## Verification
The hardest cases to reach from the ports depend on exact cycle timing. One is a trigger edge that lands while a train is running. Another is a configuration write made right after acceptance. A third is a spacing that does not divide the window evenly, so the last pulse falls just inside the window. The stimulus places trigger edges and register writes at fixed cycle offsets from the accepted trigger. It also picks window lengths one cycle past a multiple of the spacing. A behavioural model in the bench predicts the start output on every cycle, and the pulse count of each train is compared with the ceiling of window over spacing.

// File: rtl/retrig_pkg.sv
package retrig_pkg;

  // Spacing between start pulses: timeout plus guard, never below 2 cycles.
  function automatic logic [31:0] eff_period(input logic [31:0] tmo, input logic [31:0] grd);
    logic [31:0] sum;
    sum = tmo + grd;
    return (sum < 32'd2) ? 32'd2 : sum;
  endfunction

  // Window length: a zero window behaves as a single cycle.
  function automatic logic [31:0] eff_window(input logic [31:0] win);
    return (win == 32'd0) ? 32'd1 : win;
  endfunction

endpackage

// File: rtl/retrig_edge_detect.sv
module retrig_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> sig_q); // R2
endmodule

// File: rtl/retrig_cfg_latch.sv
module retrig_cfg_latch #(
  parameter int TW = 16,
  parameter int GW = 8,
  parameter int WW = 16,
  localparam int PW = ((TW > GW) ? TW : GW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [TW-1:0] cfg_timeout,
  input  logic [GW-1:0] cfg_guard,
  input  logic [WW-1:0] cfg_window,
  output logic [PW-1:0] period_q,
  output logic [WW-1:0] window_q
);
  import retrig_pkg::*;

  logic [PW-1:0] period_d;
  logic [WW-1:0] window_d;

  always_comb begin
    period_d = PW'(eff_period(32'(cfg_timeout), 32'(cfg_guard)));
    window_d = WW'(eff_window(32'(cfg_window)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PW'(2);
      window_q <= WW'(1);
    end else if (take) begin
      period_q <= period_d;
      window_q <= window_d;
    end
  end

  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    period_q >= PW'(2)); // R5
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(period_q) && $stable(window_q)); // R7
endmodule

// File: rtl/retrig_window_ctr.sv
module retrig_window_ctr #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] window_q,
  output logic          active,
  output logic          win_last
);
  logic [WW-1:0] off_q;
  logic [WW:0]   off_next;

  assign off_next = {1'b0, off_q} + {{WW{1'b0}}, 1'b1};
  assign win_last = active && (off_next >= {1'b0, window_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      off_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      off_q  <= '0;
    end else if (active) begin
      if (win_last) active <= 1'b0;
      off_q <= off_next[WW-1:0];
    end
  end

  AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !start) |=> !active); // R6
  AST_OFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, off_q} < {1'b0, window_q})); // R6
endmodule

// File: rtl/retrig_phase_timer.sv
module retrig_phase_timer #(
  parameter int PW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic          win_last,
  input  logic [PW-1:0] period_q,
  output logic          pulse_q
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_next;
  logic          wrap;

  assign wrap       = (phase_q == period_q - PW'(1));
  assign phase_next = wrap ? '0 : phase_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else if (start) begin
      phase_q <= '0;
      pulse_q <= 1'b1;
    end else if (active && !win_last) begin
      phase_q <= phase_next;
      pulse_q <= wrap;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !start) |=> !pulse_q); // R3
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (phase_q < period_q)); // R4
endmodule

// File: rtl/agc_retrig_gen.sv
module agc_retrig_gen #(
  parameter int TW = 16,
  parameter int GW = 8,
  parameter int WW = 16,
  localparam int PW = ((TW > GW) ? TW : GW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_in,
  input  logic          passthru_in,
  input  logic          mode_multi,
  input  logic [TW-1:0] cfg_timeout,
  input  logic [GW-1:0] cfg_guard,
  input  logic [WW-1:0] cfg_window,
  output logic          agc_start
);
  logic          trig_rise;
  logic          train_start;
  logic          train_active;
  logic          win_last;
  logic          pulse_q;
  logic [PW-1:0] period_q;
  logic [WW-1:0] window_q;

  retrig_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(trig_in), .rise(trig_rise)
  );

  // Accept a trigger only in train mode and only when idle.
  assign train_start = trig_rise & mode_multi & ~train_active;

  retrig_cfg_latch #(.TW(TW), .GW(GW), .WW(WW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(train_start),
    .cfg_timeout(cfg_timeout), .cfg_guard(cfg_guard), .cfg_window(cfg_window),
    .period_q(period_q), .window_q(window_q)
  );

  retrig_window_ctr #(.WW(WW)) u_win (
    .clk(clk), .rst_n(rst_n), .start(train_start), .window_q(window_q),
    .active(train_active), .win_last(win_last)
  );

  retrig_phase_timer #(.PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(train_start), .active(train_active),
    .win_last(win_last), .period_q(period_q), .pulse_q(pulse_q)
  );

  assign agc_start = mode_multi ? pulse_q : passthru_in;

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> (train_active && pulse_q)); // R2
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (train_active && !win_last) |=> ($stable(period_q) && train_active)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !train_active |-> !pulse_q); // R1
endmodule

// File: tb/agc_retrig_gen_bench.sv
module agc_retrig_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        passthru_in = 1'b0;
  logic        mode_multi = 1'b1;
  logic [15:0] cfg_timeout = 16'd0;
  logic [7:0]  cfg_guard = 8'd0;
  logic [15:0] cfg_window = 16'd0;
  logic        agc_start;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural model state
  bit m_act = 0;
  bit m_prev = 0;
  bit m_q = 0;
  int m_off = 0;
  int m_per = 2;
  int m_win = 1;

  int pulse_cnt = 0;
  bit prev_out = 0;

  agc_retrig_gen u_agc_retrig_gen (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .passthru_in(passthru_in),
    .mode_multi(mode_multi), .cfg_timeout(cfg_timeout), .cfg_guard(cfg_guard),
    .cfg_window(cfg_window), .agc_start(agc_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model advances on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_prev = 0; m_q = 0;
    end else begin
      bit rise;
      rise = trig_in && !m_prev;
      m_prev = trig_in;
      if (m_act) begin
        m_off++;
        if (m_off >= m_win) begin m_act = 0; m_q = 0; end
        else m_q = ((m_off % m_per) == 0);
      end else if (rise && mode_multi) begin
        int s;
        s = int'(cfg_timeout) + int'(cfg_guard);
        m_per = (s < 2) ? 2 : s;
        m_win = (cfg_window == 0) ? 1 : int'(cfg_window);
        m_act = 1; m_off = 0; m_q = 1;
      end
    end
  end

  // compare and count on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(agc_start), int'(mode_multi ? m_q : passthru_in));
      if (mode_multi && agc_start && prev_out) check("R3 width", 2, 1);
      if (mode_multi && agc_start && !prev_out) pulse_cnt++;
    end
    prev_out = agc_start;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run_train(input int tmo, input int grd, input int win,
                           input int exp_n, input string req);
    cur_req = req;
    cycles(1);
    cfg_timeout = 16'(tmo); cfg_guard = 8'(grd); cfg_window = 16'(win);
    pulse_cnt = 0;
    cycles(1);
    trig_in = 1'b1;
    cycles(2);
    trig_in = 1'b0;
    cycles(((win == 0) ? 1 : win) + 10);
    check({req, " count"}, pulse_cnt, exp_n);
    check({req, " idle"}, int'(agc_start), 0);
  endtask

  initial begin
    cycles(3);
    check("R1 reset", int'(agc_start), 0);
    rst_n = 1'b1;
    cycles(3);
    check("R1 after reset", int'(agc_start), 0);

    // R2: exact first-pulse cycle, then R3 drop
    cur_req = "R2";
    cfg_timeout = 16'd6; cfg_guard = 8'd0; cfg_window = 16'd30;
    pulse_cnt = 0;
    @(negedge clk); #1 trig_in = 1'b1;
    @(negedge clk);
    check("R2 first pulse", int'(agc_start), 1);
    @(negedge clk);
    check("R3 low after pulse", int'(agc_start), 0);
    #1 trig_in = 1'b0;
    cycles(40);
    check("R2 count", pulse_cnt, 5);

    run_train(20, 5, 200, 8, "R4");
    run_train(20, 0, 201, 11, "R6");
    run_train(0, 0, 11, 6, "R5");
    run_train(1, 0, 7, 4, "R5");
    run_train(9, 3, 0, 1, "R6");

    // R8: trigger while busy, then held high across the end
    cur_req = "R8";
    cfg_timeout = 16'd8; cfg_guard = 8'd2; cfg_window = 16'd100;
    pulse_cnt = 0;
    cycles(1); trig_in = 1'b1; cycles(2); trig_in = 1'b0;
    cycles(33); trig_in = 1'b1; cycles(2); trig_in = 1'b0;
    cycles(30); trig_in = 1'b1;
    cycles(60);
    check("R8 count", pulse_cnt, 10);
    trig_in = 1'b0;
    cycles(5);

    // R7: configuration change during a train
    cur_req = "R7";
    pulse_cnt = 0;
    cycles(1); trig_in = 1'b1; cycles(2); trig_in = 1'b0;
    cycles(3);
    cfg_timeout = 16'd3; cfg_guard = 8'd0; cfg_window = 16'd5;
    cycles(110);
    check("R7 count", pulse_cnt, 10);

    // R9: pass-through, and no train from edges seen in that mode
    cur_req = "R9";
    mode_multi = 1'b0;
    for (int i = 0; i < 6; i++) begin
      passthru_in = i[0];
      cycles(1);
      check("R9 follow", int'(agc_start), int'(passthru_in));
    end
    trig_in = 1'b1; cycles(2); trig_in = 1'b0; passthru_in = 1'b0;
    cycles(1);
    mode_multi = 1'b1;
    pulse_cnt = 0;
    cycles(20);
    check("R9 no train", pulse_cnt, 0);

    run_train(32768, 0, 32768, 1, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule